// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block turns single requests into the bus-cycle sequences that a parallel NOR flash expects. It covers word programming, sector erase, and entering and leaving the fast-program (unlock bypass) mode. A request is taken on a valid/ready handshake. The sequencer writes the unlock prefix and the command or data cycle. It then waits the typical operation time and polls the device until the operation completes. It finishes with a one-cycle done or error pulse. Only one operation is active at a time. The unlock addresses follow from the configured device width and byte mode. A failed program is cleaned up with a reset command, and the fast mode is left when a failure happens inside it.

The flash pins are separate address, write-data, data-enable and read-data buses, plus active-low chip enable, write enable and output enable. The write and read strobe widths are set by inputs. The program and erase waits are 2^exponent units of `TICK_CLKS` clocks each. The erase timeout is 2^(erase exponent + `ERASE_TO_SHIFT`) units.

The controller has these states: `S_IDLE`, `S_ISSUE`, `S_ISSUE_WAIT`, `S_DELAY`, `S_POLL`, `S_POLL_WAIT`, `S_EVAL`, `S_DONE` and `S_FAIL`. Its transitions are as follows:
- `S_IDLE` goes to `S_ISSUE` on an accepted request.
- `S_ISSUE` always goes to `S_ISSUE_WAIT`.
- When a bus cycle ends, `S_ISSUE_WAIT` returns to `S_ISSUE` if steps remain in the sequence. At the end of a sequence it goes to one of three states:
  - `S_DELAY` after a program or erase.
  - `S_DONE` after a mode change.
  - `S_FAIL` after cleanup, or back to `S_ISSUE` when the exit pair must still follow a reset command.
- `S_DELAY` goes to `S_POLL` when the timer expires.
- `S_POLL` always goes to `S_POLL_WAIT`.
- `S_POLL_WAIT` goes to `S_EVAL` when the read completes.
- `S_EVAL` goes to one of three states:
  - `S_POLL` to read again.
  - `S_DONE` on success.
  - `S_FAIL` on erase timeout, or `S_ISSUE` to start a reset sequence after a program mismatch.
- `S_DONE` and `S_FAIL` both return to `S_IDLE`.

The bus engine has four states. `B_IDLE` goes to `B_SETUP` on a start. `B_SETUP` goes to `B_PULSE`. `B_PULSE` goes to `B_HOLD` when the strobe count is reached. `B_HOLD` goes back to `B_IDLE`.

Top module: `nor_cmd_seq`

## Requirements
- R1: The unlock address pair (first, second) depends on `dev_width` and `byte_mode`:
  - code 0 (8-bit) gives 0x555/0x2AA.
  - code 1 (16-bit) gives 0xAAA/0x554, or 0xAAA/0x555 when `byte_mode` is 1.
  - code 2 (32-bit) gives 0x1555/0xAAA.
  - code 3 is treated as code 0.
- R2: The op codes are 0 = program, 1 = erase, 2 = enter fast mode, 3 = leave fast mode. A program outside fast mode makes four writes in this order: 0xAA to the first unlock address, 0x55 to the second, 0xA0 to the first, then the data word to `req_addr`.
- R3: Entering fast mode writes 0xAA to the first unlock address, 0x55 to the second, then 0x20 to the first, and sets `bypass_on`. Leaving it writes 0x90 then 0x00, both to address 0, and clears `bypass_on`. `bypass_on` changes only in a cycle where `op_done` or `op_error` is high.
- R4: While `bypass_on` is 1, a program makes two writes: 0xA0 to address 0, then the data to `req_addr`.
- R5: An erase writes 0xAA, 0x55, 0x80, 0xAA and 0x55 to the first, second, first, first and second unlock addresses, then 0x30 to `req_addr`.
- R6: Every bus cycle has three parts:
  - one setup clock with all strobes high;
  - `fl_ce_n` low together with `fl_we_n` (write) or `fl_oe_n` (read) for max(`wr_pulse`,1) or max(`rd_pulse`,1) clocks;
  - one hold clock with strobes high.
  The address stays stable while `fl_ce_n` is low, and `fl_we_n` and `fl_oe_n` are never low together.
- R7: After the data write of a program, no read starts within (2^`prog_exp`)·`TICK_CLKS` clocks. After the confirm write of an erase, no read starts within (2^`erase_exp`)·`TICK_CLKS` clocks.
- R8: Program polling reads `req_addr` until two consecutive reads are equal, or until `POLL_LIMIT` reads have been made. The last read is then compared with the data. A match gives `op_done`.
- R9: If that final read differs from the data, 0xF0 is written to address 0 and `op_error` is pulsed.
- R10: If a program fails while in fast mode, the writes after the data word are 0xF0, 0x90 and 0x00, all to address 0. `bypass_on` is then 0 and `op_error` is pulsed.
- R11: Erase polling reads `req_addr` until bit 7 is set, which gives `op_done`. If (2^(`erase_exp`+`ERASE_TO_SHIFT`))·`TICK_CLKS` clocks of polling pass first, `op_error` is pulsed and no reset command is written.
- R12: `req_ready` is high only when idle. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` stays low until the one-clock `op_done` or `op_error` pulse, which never occur together. `req_valid` while busy has no effect.
- R13: After reset, `req_ready` is 1, `bypass_on` is 0, all flash strobes are high, and `op_done` and `op_error` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_width | input | 2 | Device width code (0: 8-bit, 1: 16-bit, 2: 32-bit, 3: as 0) |
| byte_mode | input | 1 | A 16-bit device is wired in byte mode |
| wr_pulse | input | 4 | Write strobe width in clocks (0 acts as 1) |
| rd_pulse | input | 4 | Read strobe width in clocks (0 acts as 1) |
| prog_exp | input | 4 | Exponent of the typical program time |
| erase_exp | input | 4 | Exponent of the typical erase time |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and accepting |
| req_op | input | 2 | Operation code |
| req_addr | input | ADDR_W | Target word or sector address |
| req_data | input | DATA_W | Word to program |
| op_done | output | 1 | One-clock success pulse |
| op_error | output | 1 | One-clock failure pulse |
| bypass_on | output | 1 | Fast-program mode active |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_dq_out | output | DATA_W | Flash write data |
| fl_dq_oe | output | 1 | Drive enable for write data |
| fl_dq_in | input | DATA_W | Flash read data |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |

## Verification
The embedded assertions watch the following on every cycle:
- the strobe exclusion and address stability of each bus cycle;
- the ready drop after acceptance, and single, exclusive completion pulses;
- the poll counter never passing its limit;
- the fast-mode flag changing only at a completion;
- the wait timer never reporting expiry right after a load.

The command streams themselves can only be shown by bench scenarios against a reactive flash model. These streams are the exact address and data order of each sequence, the unlock pairs for every width setting, and the cleanup order after a failure. The same holds for the number of poll reads, the wait lengths, and the timeout path.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [1:0] {
        OP_PROG    = 2'd0,
        OP_ERASE   = 2'd1,
        OP_BYP_ON  = 2'd2,
        OP_BYP_OFF = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        SQ_PROG, SQ_PROG_BYP, SQ_ERASE, SQ_BYP_ON, SQ_BYP_OFF, SQ_RESET
    } seq_e;

    typedef enum logic [1:0] {AS_UA1, AS_UA2, AS_TGT, AS_ZERO} asel_e;

    typedef struct packed {
        asel_e      asel;
        logic       use_data;
        logic [7:0] code;
        logic       last;
    } step_t;

    function automatic step_t mk(asel_e a, logic d, logic [7:0] c, logic l);
        step_t s;
        s.asel = a; s.use_data = d; s.code = c; s.last = l;
        return s;
    endfunction

    // one entry of a command stream, selected by stream and position
    function automatic step_t seq_step(seq_e s, logic [2:0] i);
        step_t st;
        st = mk(AS_ZERO, 1'b0, 8'hF0, 1'b1);
        case (s)
            SQ_PROG: case (i)
                3'd0:    st = mk(AS_UA1, 1'b0, 8'hAA, 1'b0);
                3'd1:    st = mk(AS_UA2, 1'b0, 8'h55, 1'b0);
                3'd2:    st = mk(AS_UA1, 1'b0, 8'hA0, 1'b0);
                default: st = mk(AS_TGT, 1'b1, 8'h00, 1'b1);
            endcase
            SQ_PROG_BYP: case (i)
                3'd0:    st = mk(AS_ZERO, 1'b0, 8'hA0, 1'b0);
                default: st = mk(AS_TGT, 1'b1, 8'h00, 1'b1);
            endcase
            SQ_ERASE: case (i)
                3'd0:    st = mk(AS_UA1, 1'b0, 8'hAA, 1'b0);
                3'd1:    st = mk(AS_UA2, 1'b0, 8'h55, 1'b0);
                3'd2:    st = mk(AS_UA1, 1'b0, 8'h80, 1'b0);
                3'd3:    st = mk(AS_UA1, 1'b0, 8'hAA, 1'b0);
                3'd4:    st = mk(AS_UA2, 1'b0, 8'h55, 1'b0);
                default: st = mk(AS_TGT, 1'b0, 8'h30, 1'b1);
            endcase
            SQ_BYP_ON: case (i)
                3'd0:    st = mk(AS_UA1, 1'b0, 8'hAA, 1'b0);
                3'd1:    st = mk(AS_UA2, 1'b0, 8'h55, 1'b0);
                default: st = mk(AS_UA1, 1'b0, 8'h20, 1'b1);
            endcase
            SQ_BYP_OFF: case (i)
                3'd0:    st = mk(AS_ZERO, 1'b0, 8'h90, 1'b0);
                default: st = mk(AS_ZERO, 1'b0, 8'h00, 1'b1);
            endcase
            default: st = mk(AS_ZERO, 1'b0, 8'hF0, 1'b1);
        endcase
        return st;
    endfunction

    // unlock address by device width; second=1 picks the second address
    function automatic logic [12:0] unlock_addr(logic [1:0] dw, logic bm, logic second);
        logic [12:0] a;
        case (dw)
            2'd1:    a = second ? (bm ? 13'h0555 : 13'h0554) : 13'h0AAA;
            2'd2:    a = second ? 13'h0AAA : 13'h1555;
            default: a = second ? 13'h02AA : 13'h0555;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/nor_bus_cycle.sv
module nor_bus_cycle #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int PW_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PW_W-1:0]   wr_pulse,
    input  logic [PW_W-1:0]   rd_pulse,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_dq_out,
    output logic              fl_dq_oe,
    input  logic [DATA_W-1:0] fl_dq_in,
    output logic              fl_ce_n,
    output logic              fl_we_n,
    output logic              fl_oe_n
);
    typedef enum logic [1:0] {B_IDLE, B_SETUP, B_PULSE, B_HOLD} bstate_e;

    bstate_e           state, next;
    logic              rd_r;
    logic [ADDR_W-1:0] addr_r;
    logic [DATA_W-1:0] data_r;
    logic [PW_W-1:0]   cnt, width, lim;

    always_comb begin
        width = rd_r ? rd_pulse : wr_pulse;
        lim   = (width == '0) ? PW_W'(1) : width;
    end

    always_comb begin
        next = state;
        unique case (state)
            B_IDLE:  if (start) next = B_SETUP;
            B_SETUP: next = B_PULSE;
            B_PULSE: if (cnt == lim) next = B_HOLD;
            B_HOLD:  next = B_IDLE;
            default: next = B_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= B_IDLE;
        else        state <= next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_r   <= 1'b0;
            addr_r <= '0;
            data_r <= '0;
            cnt    <= '0;
            rdata  <= '0;
        end else begin
            if (state == B_IDLE && start) begin
                rd_r   <= rd;
                addr_r <= addr;
                data_r <= wdata;
            end
            if (state == B_SETUP)      cnt <= PW_W'(1);
            else if (state == B_PULSE) cnt <= cnt + 1'b1;
            if (state == B_PULSE && cnt == lim && rd_r) rdata <= fl_dq_in;
        end
    end

    always_comb begin
        fl_addr   = addr_r;
        fl_dq_out = data_r;
        fl_dq_oe  = !rd_r && (state != B_IDLE);
        fl_ce_n   = !(state == B_PULSE);
        fl_we_n   = !(state == B_PULSE && !rd_r);
        fl_oe_n   = !(state == B_PULSE && rd_r);
        done      = (state == B_HOLD);
    end

    a_r6_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_we_n && !fl_oe_n));
    a_r6_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_ce_n && $past(!fl_ce_n)) |-> $stable(fl_addr));
    a_r6_hold_after: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_ce_n) |-> done);

endmodule

// File: rtl/nor_wait_timer.sv
module nor_wait_timer #(
    parameter int TICK_CLKS = 100,
    parameter int CNT_W     = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [4:0] exp_sel,
    output logic       expired
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] load;

    assign load    = CNT_W'(TICK_CLKS) << exp_sel;
    assign expired = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= load;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    a_r7_no_early_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !expired);

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int ADDR_W         = 24,
    parameter int DATA_W         = 16,
    parameter int TICK_CLKS      = 100,
    parameter int POLL_LIMIT     = 10000,
    parameter int ERASE_TO_SHIFT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        dev_width,
    input  logic              byte_mode,
    input  logic [3:0]        wr_pulse,
    input  logic [3:0]        rd_pulse,
    input  logic [3:0]        prog_exp,
    input  logic [3:0]        erase_exp,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              op_done,
    output logic              op_error,
    output logic              bypass_on,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_dq_out,
    output logic              fl_dq_oe,
    input  logic [DATA_W-1:0] fl_dq_in,
    output logic              fl_ce_n,
    output logic              fl_we_n,
    output logic              fl_oe_n
);
    localparam int PC_W = $clog2(POLL_LIMIT + 1);

    typedef enum logic [3:0] {
        S_IDLE, S_ISSUE, S_ISSUE_WAIT, S_DELAY, S_POLL,
        S_POLL_WAIT, S_EVAL, S_DONE, S_FAIL
    } state_e;

    state_e            state, next;
    seq_e              seq_r;
    logic [2:0]        idx_r;
    logic [ADDR_W-1:0] addr_r;
    logic [DATA_W-1:0] data_r, prev_rd;
    logic [PC_W-1:0]   poll_cnt;
    logic              byp_r, fail_pend;
    step_t             step;
    logic [ADDR_W-1:0] cmd_addr, bus_addr;
    logic [DATA_W-1:0] cmd_data, bus_rdata;
    logic              bus_start, bus_rd, bus_done;
    logic              tmr_start, tmr_expired;
    logic [4:0]        tmr_exp;
    logic              is_prog, is_erase, settled, mismatch;

    assign step     = seq_step(seq_r, idx_r);
    assign is_prog  = (seq_r == SQ_PROG) || (seq_r == SQ_PROG_BYP);
    assign is_erase = (seq_r == SQ_ERASE);
    assign settled  = ((poll_cnt != '0) && (bus_rdata == prev_rd))
                      || (poll_cnt == PC_W'(POLL_LIMIT - 1));
    assign mismatch = (bus_rdata != data_r);

    always_comb begin
        unique case (step.asel)
            AS_UA1:  cmd_addr = ADDR_W'(unlock_addr(dev_width, byte_mode, 1'b0));
            AS_UA2:  cmd_addr = ADDR_W'(unlock_addr(dev_width, byte_mode, 1'b1));
            AS_TGT:  cmd_addr = addr_r;
            default: cmd_addr = '0;
        endcase
        cmd_data = step.use_data ? data_r : DATA_W'(step.code);
    end

    // next-state logic
    always_comb begin
        next = state;
        unique case (state)
            S_IDLE:       if (req_valid) next = S_ISSUE;
            S_ISSUE:      next = S_ISSUE_WAIT;
            S_ISSUE_WAIT: if (bus_done) begin
                if (!step.last) next = S_ISSUE;
                else begin
                    case (seq_r)
                        SQ_BYP_ON:  next = S_DONE;
                        SQ_BYP_OFF: next = fail_pend ? S_FAIL : S_DONE;
                        SQ_RESET:   next = byp_r ? S_ISSUE : S_FAIL;
                        default:    next = S_DELAY;
                    endcase
                end
            end
            S_DELAY:      if (tmr_expired) next = S_POLL;
            S_POLL:       next = S_POLL_WAIT;
            S_POLL_WAIT:  if (bus_done) next = S_EVAL;
            S_EVAL: begin
                if (is_erase)
                    next = bus_rdata[7] ? S_DONE : (tmr_expired ? S_FAIL : S_POLL);
                else if (settled)
                    next = mismatch ? S_ISSUE : S_DONE;
                else
                    next = S_POLL;
            end
            S_DONE:       next = S_IDLE;
            S_FAIL:       next = S_IDLE;
            default:      next = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= next;
    end

    // operation context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_r     <= SQ_RESET;
            idx_r     <= '0;
            addr_r    <= '0;
            data_r    <= '0;
            prev_rd   <= '0;
            poll_cnt  <= '0;
            byp_r     <= 1'b0;
            fail_pend <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (req_valid) begin
                    addr_r    <= req_addr;
                    data_r    <= req_data;
                    idx_r     <= '0;
                    fail_pend <= 1'b0;
                    case (op_e'(req_op))
                        OP_PROG:   seq_r <= byp_r ? SQ_PROG_BYP : SQ_PROG;
                        OP_ERASE:  seq_r <= SQ_ERASE;
                        OP_BYP_ON: seq_r <= SQ_BYP_ON;
                        default:   seq_r <= SQ_BYP_OFF;
                    endcase
                end
                S_ISSUE_WAIT: if (bus_done) begin
                    if (!step.last) idx_r <= idx_r + 1'b1;
                    else begin
                        poll_cnt <= '0;
                        case (seq_r)
                            SQ_BYP_ON:  byp_r <= 1'b1;
                            SQ_BYP_OFF: byp_r <= 1'b0;
                            SQ_RESET: if (byp_r) begin
                                seq_r <= SQ_BYP_OFF;
                                idx_r <= '0;
                            end
                            default: ;
                        endcase
                    end
                end
                S_EVAL: if (is_prog) begin
                    if (settled) begin
                        if (mismatch) begin
                            seq_r     <= SQ_RESET;
                            idx_r     <= '0;
                            fail_pend <= 1'b1;
                        end
                    end else begin
                        prev_rd  <= bus_rdata;
                        poll_cnt <= poll_cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs and sub-block controls
    always_comb begin
        req_ready = (state == S_IDLE);
        op_done   = (state == S_DONE);
        op_error  = (state == S_FAIL);
        bypass_on = byp_r;
        bus_start = (state == S_ISSUE) || (state == S_POLL);
        bus_rd    = (state == S_POLL);
        bus_addr  = bus_rd ? addr_r : cmd_addr;
        tmr_start = 1'b0;
        tmr_exp   = {1'b0, prog_exp};
        if (state == S_ISSUE_WAIT && bus_done && step.last && (is_prog || is_erase)) begin
            tmr_start = 1'b1;
            tmr_exp   = is_erase ? {1'b0, erase_exp} : {1'b0, prog_exp};
        end else if (state == S_DELAY && tmr_expired && is_erase) begin
            tmr_start = 1'b1;
            tmr_exp   = {1'b0, erase_exp} + 5'(ERASE_TO_SHIFT);
        end
    end

    nor_bus_cycle #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PW_W(4)) u_bus (
        .clk(clk), .rst_n(rst_n), .start(bus_start), .rd(bus_rd),
        .addr(bus_addr), .wdata(cmd_data), .wr_pulse(wr_pulse), .rd_pulse(rd_pulse),
        .done(bus_done), .rdata(bus_rdata), .fl_addr(fl_addr), .fl_dq_out(fl_dq_out),
        .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n),
        .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
    );

    nor_wait_timer #(.TICK_CLKS(TICK_CLKS), .CNT_W(32)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .exp_sel(tmr_exp),
        .expired(tmr_expired)
    );

    a_r12_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    a_r12_excl_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_done && op_error));
    a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done || op_error) |=> (!op_done && !op_error && req_ready));
    a_r8_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
        poll_cnt <= PC_W'(POLL_LIMIT));
    a_r3_bypass_set: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bypass_on) |-> op_done);
    a_r3_bypass_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bypass_on) |-> (op_done || op_error));

endmodule

// File: tb/nor_cmd_seq_test.sv
module nor_cmd_seq_test;
    localparam int AW = 24, DW = 16, TICK = 2, PLIM = 16, TOS = 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic [1:0]    dev_width = 2'd0;
    logic          byte_mode = 1'b0;
    logic [3:0]    wr_pulse = 4'd1, rd_pulse = 4'd1, prog_exp = 4'd1, erase_exp = 4'd1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          op_done, op_error, bypass_on;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_dq_out;
    logic          fl_dq_oe;
    logic [DW-1:0] fl_dq_in = '0;
    logic          fl_ce_n, fl_we_n, fl_oe_n;

    nor_cmd_seq #(.ADDR_W(AW), .DATA_W(DW), .TICK_CLKS(TICK), .POLL_LIMIT(PLIM),
                  .ERASE_TO_SHIFT(TOS)) uut (
        .clk(clk), .rst_n(rst_n), .dev_width(dev_width), .byte_mode(byte_mode),
        .wr_pulse(wr_pulse), .rd_pulse(rd_pulse), .prog_exp(prog_exp),
        .erase_exp(erase_exp), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .op_done(op_done), .op_error(op_error), .bypass_on(bypass_on),
        .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
        .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
    );

    int tests = 0, fails = 0, cyc = 0;
    bit finished = 1'b0;
    always @(posedge clk) cyc++;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // flash model: logs writes, answers reads, measures strobe widths
    logic [AW-1:0] lg_a [0:15];
    logic [DW-1:0] lg_d [0:15];
    int nwr = 0, nrd = 0, wcnt = 0, rcnt = 0, wlen = 0, rlen = 0;
    int wrise_cyc = 0, rd1_cyc = 0, mode = 0, kflip = 0;
    bit pwe = 1'b1, poe = 1'b1;
    logic [DW-1:0] good_v = '0, final_v = '0;

    function automatic logic [DW-1:0] model(int n);
        if (mode == 1) return (n <= kflip) ? 16'h0000 : 16'h0080;
        if (n <= kflip) return good_v ^ ((n % 2 == 1) ? 16'h0001 : 16'h0002);
        return final_v;
    endfunction

    always @(negedge clk) begin
        if (!fl_we_n && pwe && !fl_ce_n) begin
            if (nwr < 16) begin lg_a[nwr] = fl_addr; lg_d[nwr] = fl_dq_out; end
            nwr++;
        end
        if (!fl_we_n) wcnt++;
        else if (!pwe) begin wlen = wcnt; wcnt = 0; wrise_cyc = cyc; end
        if (!fl_oe_n && poe) begin
            nrd++;
            if (nrd == 1) rd1_cyc = cyc;
            fl_dq_in = model(nrd);
        end
        if (!fl_oe_n) rcnt++;
        else if (!poe) begin rlen = rcnt; rcnt = 0; end
        pwe = fl_we_n;
        poe = fl_oe_n;
    end

    function automatic logic [AW-1:0] ua(int dw, bit bm, bit second);
        if (dw == 1) return second ? (bm ? 24'h555 : 24'h554) : 24'hAAA;
        if (dw == 2) return second ? 24'hAAA : 24'h1555;
        return second ? 24'h2AA : 24'h555;
    endfunction

    task automatic chk_wr(int i, logic [AW-1:0] a, logic [DW-1:0] d, string req);
        check(lg_a[i] == a, req, $sformatf("write %0d address", i), lg_a[i], a);
        check(lg_d[i] == d, req, $sformatf("write %0d data", i), lg_d[i], d);
    endtask

    bit r_done, r_err;
    int acc_cyc, end_cyc;

    task automatic run(input logic [1:0] op, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input bit poke);
        int n;
        nwr = 0; nrd = 0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_op = op; req_addr = a; req_data = d; req_valid = 1'b1;
        @(negedge clk);
        acc_cyc = cyc;
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R12", "ready after accept", req_ready, 0);
        if (poke) begin
            @(negedge clk); @(negedge clk);
            req_op = 2'd3; req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        n = 0;
        while (!op_done && !op_error && n < 5000) begin @(negedge clk); n++; end
        r_done = op_done; r_err = op_error; end_cyc = cyc;
        check(!(op_done && op_error), "R12", "done with error", {op_done, op_error}, 2);
        @(negedge clk);
        check(req_ready && !op_done && !op_error, "R12", "pulse ends, ready back",
              {req_ready, op_done, op_error}, 3'b100);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL R12 watchdog: actual hung expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] ta;
        repeat (3) @(negedge clk);
        // R13 reset state
        check(req_ready == 1'b1, "R13", "ready in reset", req_ready, 1);
        check({fl_ce_n, fl_we_n, fl_oe_n} == 3'b111, "R13", "strobes in reset",
              {fl_ce_n, fl_we_n, fl_oe_n}, 3'b111);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !bypass_on && !op_done && !op_error, "R13", "state after reset",
              {req_ready, bypass_on, op_done, op_error}, 4'b1000);

        // R1 R2 R6 R7 R8 sweep over width settings, strobe widths and settle lengths
        for (int c = 0; c < 8; c++) begin
            dev_width = 2'(c >> 1); byte_mode = c[0];
            wr_pulse = 4'(c % 4); rd_pulse = 4'((c + 1) % 4); prog_exp = 4'(c % 3);
            mode = 0; kflip = c % 4;
            good_v = 16'h1234 + 16'(c * 16'h0101); final_v = good_v;
            ta = 24'h010000 + 24'(c * 24'h40);
            run(2'd0, ta, good_v, 1'b0);
            check(r_done && !r_err, "R8", "program result", {r_done, r_err}, 2'b10);
            check(nwr == 4, "R2", "program write count", nwr, 4);
            chk_wr(0, ua(c >> 1, c[0], 1'b0), 16'h00AA, "R1");
            chk_wr(1, ua(c >> 1, c[0], 1'b1), 16'h0055, "R1");
            chk_wr(2, ua(c >> 1, c[0], 1'b0), 16'h00A0, "R2");
            chk_wr(3, ta, good_v, "R2");
            check(nrd == kflip + 2, "R8", "settle read count", nrd, kflip + 2);
            check(wlen == ((c % 4) == 0 ? 1 : c % 4), "R6", "write strobe width",
                  wlen, (c % 4) == 0 ? 1 : c % 4);
            check(rlen == (((c + 1) % 4) == 0 ? 1 : (c + 1) % 4), "R6", "read strobe width",
                  rlen, ((c + 1) % 4) == 0 ? 1 : (c + 1) % 4);
            check(rd1_cyc - wrise_cyc >= (TICK << (c % 3)), "R7", "program wait",
                  rd1_cyc - wrise_cyc, TICK << (c % 3));
        end

        dev_width = 2'd0; byte_mode = 1'b0; wr_pulse = 4'd2; rd_pulse = 4'd1; prog_exp = 4'd1;

        // R9 mismatch after settling
        mode = 0; kflip = 1; good_v = 16'hBEEF; final_v = 16'hBEEF ^ 16'h0100;
        run(2'd0, 24'h000100, good_v, 1'b0);
        check(r_err && !r_done, "R9", "mismatch result", {r_done, r_err}, 2'b01);
        check(nwr == 5, "R9", "mismatch write count", nwr, 5);
        chk_wr(4, 24'h0, 16'h00F0, "R9");

        // R8 limit: never stable, final read differs
        mode = 0; kflip = 1000; good_v = 16'h0F0F; final_v = good_v;
        run(2'd0, 24'h000200, good_v, 1'b0);
        check(nrd == PLIM, "R8", "reads at limit", nrd, PLIM);
        check(r_err, "R8", "limit result error", r_err, 1);
        chk_wr(4, 24'h0, 16'h00F0, "R8");

        // R3 fast mode entry
        run(2'd2, 24'h0, 16'h0, 1'b0);
        check(r_done && bypass_on, "R3", "entry done and flag", {r_done, bypass_on}, 2'b11);
        check(nwr == 3, "R3", "entry write count", nwr, 3);
        chk_wr(0, 24'h555, 16'h00AA, "R3");
        chk_wr(1, 24'h2AA, 16'h0055, "R3");
        chk_wr(2, 24'h555, 16'h0020, "R3");

        // R4 fast program, with an ignored request poked while busy (R12)
        mode = 0; kflip = 0; good_v = 16'h5A5A; final_v = good_v;
        run(2'd0, 24'h000300, good_v, 1'b1);
        check(r_done, "R4", "fast program done", r_done, 1);
        check(nwr == 2, "R4", "fast program write count", nwr, 2);
        chk_wr(0, 24'h0, 16'h00A0, "R4");
        chk_wr(1, 24'h000300, 16'h5A5A, "R4");
        check(bypass_on == 1'b1, "R12", "busy request ignored, still fast", bypass_on, 1);
        repeat (4) @(negedge clk);
        check(req_ready && nwr == 2, "R12", "no later op from ignored request",
              nwr, 2);

        // R10 failing fast program
        mode = 0; kflip = 0; good_v = 16'h1111; final_v = 16'h1011;
        run(2'd0, 24'h000400, good_v, 1'b0);
        check(r_err, "R10", "fast failure error", r_err, 1);
        check(nwr == 5, "R10", "fast failure write count", nwr, 5);
        chk_wr(2, 24'h0, 16'h00F0, "R10");
        chk_wr(3, 24'h0, 16'h0090, "R10");
        chk_wr(4, 24'h0, 16'h0000, "R10");
        check(bypass_on == 1'b0, "R10", "fast flag cleared", bypass_on, 0);

        // R3 normal exit
        run(2'd2, 24'h0, 16'h0, 1'b0);
        run(2'd3, 24'h0, 16'h0, 1'b0);
        check(r_done && !bypass_on, "R3", "exit done, flag clear", {r_done, bypass_on}, 2'b10);
        check(nwr == 2, "R3", "exit write count", nwr, 2);
        chk_wr(0, 24'h0, 16'h0090, "R3");
        chk_wr(1, 24'h0, 16'h0000, "R3");

        // R5 R11 erase success on a 32-bit device
        dev_width = 2'd2; erase_exp = 4'd1; mode = 1; kflip = 2;
        run(2'd1, 24'h020000, 16'h0, 1'b0);
        check(r_done, "R11", "erase done", r_done, 1);
        check(nwr == 6, "R5", "erase write count", nwr, 6);
        chk_wr(0, 24'h1555, 16'h00AA, "R5");
        chk_wr(1, 24'h0AAA, 16'h0055, "R5");
        chk_wr(2, 24'h1555, 16'h0080, "R5");
        chk_wr(3, 24'h1555, 16'h00AA, "R5");
        chk_wr(4, 24'h0AAA, 16'h0055, "R5");
        chk_wr(5, 24'h020000, 16'h0030, "R5");
        check(nrd == 3, "R11", "erase poll reads", nrd, 3);
        check(rd1_cyc - wrise_cyc >= (TICK << 1), "R7", "erase wait",
              rd1_cyc - wrise_cyc, TICK << 1);

        // R11 erase timeout
        erase_exp = 4'd2; kflip = 100000;
        run(2'd1, 24'h030000, 16'h0, 1'b0);
        check(r_err && !r_done, "R11", "erase timeout error", {r_done, r_err}, 2'b01);
        check(nwr == 6, "R11", "no reset after timeout", nwr, 6);
        check(end_cyc - rd1_cyc >= (TICK << (2 + TOS)) - 4, "R11", "timeout length",
              end_cyc - rd1_cyc, (TICK << (2 + TOS)) - 4);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule